// File: doc/BRIEF.md
# Predicated Rounding-Average Vector Unit

This unit is one pipeline stage of a vector datapath. It treats two source vectors as packed unsigned lanes whose width (8, 16, 32 or 64 bits) is chosen at run time by a 2-bit size code. Every lane the predicate enables receives the rounded average of its two operands. Every disabled lane keeps the value of the first source. The first source is also the destination, so disabled lanes of the destination come through unchanged.

The unit also decodes the 32-bit instruction word that carries the size code, the predicate register index and the two vector register indices. It flags whether the word is this operation. A word that does not match passes the first source through untouched and raises an illegal flag. Inputs are captured on a clock edge when `in_valid` is high, and the result appears one cycle later. The register files, exception handling and other vector operations live outside this block.

Top module: `simd_ravg_unit`

## Requirements
- R1: Lane width is 8 << size, where size = insn[23:22]: 00 selects 8-bit lanes, 01 16-bit, 10 32-bit and 11 64-bit. A `VEC_W`-bit vector holds VEC_W/width lanes, and lane e occupies bits [e*width +: width].
- R2: An active lane yields bits [width:1] of the (width+1)-bit unsigned sum a + b + 1. The carry-out becomes the top bit of the result, with no sign extension. For example, all-ones plus zero gives only the MSB set.
- R3: An inactive lane yields the first source's lane unchanged, whatever the second source holds.
- R4: The predicate has one bit per byte. Lane e is active exactly when predicate bit e*(width/8) is 1. The other bits of that lane's byte group have no effect.
- R5: The word matches only when insn[31:24] = 8'h44 and insn[21:13] = 9'b010101100. The outputs carry size = insn[23:22], predicate index = insn[12:10], second register = insn[9:5] and first/destination register = insn[4:0].
- R6: On a matching word, out_match = 1 and out_illegal = 0. On a non-matching word, out_match = 0, out_illegal = 1 and the result equals the first source.
- R7: out_valid rises exactly one cycle after a cycle with in_valid = 1 and is low after a cycle with in_valid = 0. While in_valid is low, result and the decoded outputs hold their last values.
- R8: While rst_n is low, out_valid is 0. The reset release is synchronised to the clock, so out_valid stays 0 until valid input arrives after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for the inputs |
| insn | input | 32 | Instruction word |
| src_a | input | VEC_W | First source (also the merge value) |
| src_b | input | VEC_W | Second source |
| pred | input | VEC_W/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid, one cycle after capture |
| result | output | VEC_W | Merged lane results |
| out_match | output | 1 | Instruction word matched |
| out_illegal | output | 1 | Instruction word did not match |
| out_size | output | 2 | Decoded size code |
| out_pg | output | 3 | Decoded predicate register index |
| out_zm | output | 5 | Decoded second register index |
| out_zdn | output | 5 | Decoded first/destination register index |

## Verification
The hardest case to reach is the carry into each lane's top bit. It appears only when the lane sum overflows the lane width, and it must land in the MSB of that same lane, never in the next lane. The stimulus forces it with all-ones operands and with all-ones plus zero for every size code, and compares every lane. Random predicates almost never leave the low bit of a group clear while the other bits of the group are set. So dedicated patterns set only the non-governing bits, or only the governing bits, to show that only the lowest bit of each group counts.

// File: rtl/simd_ravg_pkg.sv
package simd_ravg_pkg;

  localparam logic [7:0] OPC_HI = 8'h44;
  localparam logic [8:0] OPC_MID = 9'b010101100;
  localparam int SIZE_CODES = 4;
  localparam int CHUNK_W = 64;
  localparam int CHUNK_BYTES = CHUNK_W / 8;

  typedef struct packed {
    logic       match;
    logic [1:0] size;
    logic [2:0] pg;
    logic [4:0] zm;
    logic [4:0] zdn;
  } insn_fields_t;

endpackage

// File: rtl/simd_ravg_dec.sv
module simd_ravg_dec
  import simd_ravg_pkg::*;
(
  input  logic [31:0]  insn,
  output insn_fields_t fields
);

  logic hi_ok;
  logic mid_ok;

  always_comb begin
    hi_ok        = (insn[31:24] == OPC_HI);
    mid_ok       = (insn[21:13] == OPC_MID);
    fields.match = hi_ok & mid_ok;
    fields.size  = insn[23:22];
    fields.pg    = insn[12:10];
    fields.zm    = insn[9:5];
    fields.zdn   = insn[4:0];
  end

endmodule

// File: rtl/simd_ravg_chunk.sv
module simd_ravg_chunk
  import simd_ravg_pkg::*;
(
  input  logic [CHUNK_W-1:0]     a,
  input  logic [CHUNK_W-1:0]     b,
  input  logic [CHUNK_BYTES-1:0] pbits,
  input  logic [1:0]             size,
  output logic [CHUNK_W-1:0]     y
);

  logic [SIZE_CODES-1:0][CHUNK_W-1:0]     avg_c;
  logic [SIZE_CODES-1:0][CHUNK_BYTES-1:0] act_c;
  logic [CHUNK_W-1:0]     avg_sel;
  logic [CHUNK_BYTES-1:0] act_sel;

  for (genvar s = 0; s < SIZE_CODES; s++) begin : g_size
    localparam int ESZ = 8 << s;
    localparam int NL  = CHUNK_W / ESZ;
    localparam int BPL = ESZ / 8;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [ESZ:0] sum;
      assign sum = {1'b0, a[l*ESZ +: ESZ]} + {1'b0, b[l*ESZ +: ESZ]}
                 + {{ESZ{1'b0}}, 1'b1};
      assign avg_c[s][l*ESZ +: ESZ] = sum[ESZ:1];
      for (genvar k = 0; k < BPL; k++) begin : g_byte
        assign act_c[s][l*BPL + k] = pbits[l*BPL];
      end
    end
  end

  always_comb begin
    avg_sel = avg_c[size];
    act_sel = act_c[size];
    for (int k = 0; k < CHUNK_BYTES; k++) begin
      y[k*8 +: 8] = act_sel[k] ? avg_sel[k*8 +: 8] : a[k*8 +: 8];
    end
  end

endmodule

// File: rtl/simd_ravg_rst_sync.sv
module simd_ravg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/simd_ravg_unit.sv
module simd_ravg_unit
  import simd_ravg_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        insn,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               out_match,
  output logic               out_illegal,
  output logic [1:0]         out_size,
  output logic [2:0]         out_pg,
  output logic [4:0]         out_zm,
  output logic [4:0]         out_zdn
);

  localparam int NCHUNK = VEC_W / CHUNK_W;

  if (VEC_W % CHUNK_W != 0) begin : g_bad_width
    $error("VEC_W must be a multiple of 64");
  end

  logic         rst_sync_n;
  insn_fields_t dec;
  logic [VEC_W-1:0] merged;

  simd_ravg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  simd_ravg_dec u_dec (
    .insn   (insn),
    .fields (dec)
  );

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    simd_ravg_chunk u_chunk (
      .a     (src_a[c*CHUNK_W +: CHUNK_W]),
      .b     (src_b[c*CHUNK_W +: CHUNK_W]),
      .pbits (pred[c*CHUNK_BYTES +: CHUNK_BYTES]),
      .size  (dec.size),
      .y     (merged[c*CHUNK_W +: CHUNK_W])
    );
  end

  // next-state
  logic             valid_d;
  logic             cap_en;
  logic [VEC_W-1:0] res_d;
  logic             match_d;
  logic             ill_d;

  always_comb begin
    valid_d = in_valid;
    cap_en  = in_valid;
    match_d = dec.match;
    ill_d   = ~dec.match;
    res_d   = dec.match ? merged : src_a;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_match   <= 1'b0;
      out_illegal <= 1'b0;
    end else if (cap_en) begin
      out_match   <= match_d;
      out_illegal <= ill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      result   <= res_d;
      out_size <= dec.size;
      out_pg   <= dec.pg;
      out_zm   <= dec.zm;
      out_zdn  <= dec.zdn;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R7
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_match != out_illegal)); // R6
  AST_NOMATCH_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !dec.match) |=> (result == $past(src_a))); // R6
  AST_NO_PRED_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && pred == '0) |=> (result == $past(src_a))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_zdn) && $stable(out_size)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !out_valid); // R8

endmodule

// File: tb/test_simd_ravg_unit.sv
`timescale 1ns/1ps
module test_simd_ravg_unit;
  localparam int VW = 256;
  localparam int PW = VW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   insn;
  logic [VW-1:0] src_a, src_b;
  logic [PW-1:0] pred;
  logic          out_valid, out_match, out_illegal;
  logic [VW-1:0] result;
  logic [1:0]    out_size;
  logic [2:0]    out_pg;
  logic [4:0]    out_zm, out_zdn;

  int n_tests = 0;
  int n_fail  = 0;

  // expected state
  logic          e_valid;
  logic [VW-1:0] e_res;
  logic          e_match, e_ill;
  logic [1:0]    e_size;
  logic [2:0]    e_pg;
  logic [4:0]    e_zm, e_zdn;
  bit            have_data = 0;

  always #4 clk = ~clk;

  simd_ravg_unit #(.VEC_W(VW)) i_simd_ravg_unit (
    .clk, .rst_n, .in_valid, .insn, .src_a, .src_b, .pred,
    .out_valid, .result, .out_match, .out_illegal,
    .out_size, .out_pg, .out_zm, .out_zdn
  );

  function automatic logic [31:0] mk_insn(logic [1:0] sz, logic [2:0] pg,
                                          logic [4:0] zm, logic [4:0] zdn);
    return {8'h44, sz, 9'b010101100, pg, zm, zdn};
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PW-1:0] rnd_pred();
    logic [PW-1:0] v;
    for (int i = 0; i < (PW+31)/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // governing-bit mask: bit e*(width/8) for every lane e
  function automatic logic [PW-1:0] gov_mask(int sz);
    logic [PW-1:0] m = '0;
    int bpl = 1 << sz;
    for (int e = 0; e < PW/bpl; e++) m[e*bpl] = 1'b1;
    return m;
  endfunction

  function automatic logic [VW-1:0] ref_avg(int sz, logic [VW-1:0] a,
                                            logic [VW-1:0] b, logic [PW-1:0] p);
    logic [VW-1:0] r;
    int esz = 8 << sz;
    for (int e = 0; e < VW/esz; e++) begin
      logic [VW-1:0] ta, tb;
      logic [64:0]   x, y, s, msk;
      ta  = a >> (e*esz);
      tb  = b >> (e*esz);
      msk = (65'd1 << esz) - 65'd1;
      x   = {1'b0, ta[63:0]} & msk;
      y   = {1'b0, tb[63:0]} & msk;
      s   = x + y + 65'd1;
      s   = s >> 1;
      for (int k = 0; k < esz; k++)
        r[e*esz + k] = p[e*(esz/8)] ? s[k] : a[e*esz + k];
    end
    return r;
  endfunction

  task automatic step(string tag, bit v, logic [31:0] w, logic [VW-1:0] a,
                      logic [VW-1:0] b, logic [PW-1:0] p);
    bit ok;
    in_valid = v; insn = w; src_a = a; src_b = b; pred = p;
    e_valid = v;
    if (v) begin
      e_match = (w[31:24] == 8'h44) && (w[21:13] == 9'b010101100);
      e_ill   = !e_match;
      e_size  = w[23:22]; e_pg = w[12:10]; e_zm = w[9:5]; e_zdn = w[4:0];
      e_res   = e_match ? ref_avg(int'(w[23:22]), a, b, p) : a;
      have_data = 1;
    end
    @(negedge clk);
    n_tests++;
    ok = (out_valid === e_valid);
    if (have_data)
      ok = ok && (result === e_res) && (out_match === e_match) &&
           (out_illegal === e_ill) && (out_size === e_size) &&
           (out_pg === e_pg) && (out_zm === e_zm) && (out_zdn === e_zdn);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual v=%b m=%b i=%b f=%h/%h/%h/%h res=%h expected v=%b m=%b i=%b f=%h/%h/%h/%h res=%h",
               tag, out_valid, out_match, out_illegal, out_size, out_pg, out_zm, out_zdn, result,
               e_valid, e_match, e_ill, e_size, e_pg, e_zm, e_zdn, e_res);
    end
  endtask

  task automatic chk_idle(string tag);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: actual out_valid=%b expected 0", tag, out_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [VW-1:0] ones = '1;
    rst_n = 1'b0; in_valid = 1'b0; insn = '0;
    src_a = '0; src_b = '0; pred = '0;
    repeat (3) @(negedge clk);
    chk_idle("R8 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R8 release");
    repeat (3) @(negedge clk);
    chk_idle("R8 after release");

    for (int sz = 0; sz < 4; sz++) begin
      logic [1:0] s2 = 2'(sz);
      for (int i = 0; i < 6; i++)
        step("R1 random", 1, mk_insn(s2, 3'(i), 5'(i+sz), 5'(31-i)),
             rnd_vec(), rnd_vec(), rnd_pred());
      step("R2 all ones", 1, mk_insn(s2, 3'd7, 5'd1, 5'd2), ones, ones, '1);
      step("R2 carry to MSB", 1, mk_insn(s2, 3'd0, 5'd3, 5'd4), ones, '0, '1);
      step("R2 carry swapped", 1, mk_insn(s2, 3'd1, 5'd5, 5'd6), '0, ones, '1);
      step("R3 none active", 1, mk_insn(s2, 3'd2, 5'd7, 5'd8), rnd_vec(), ones, '0);
      step("R3 alt predicate", 1, mk_insn(s2, 3'd3, 5'd9, 5'd10), rnd_vec(), rnd_vec(),
           {PW/2{2'b01}});
      step("R4 non-governing only", 1, mk_insn(s2, 3'd4, 5'd11, 5'd12),
           rnd_vec(), rnd_vec(), ~gov_mask(sz));
      step("R4 governing only", 1, mk_insn(s2, 3'd5, 5'd13, 5'd14),
           rnd_vec(), rnd_vec(), gov_mask(sz));
      step("R7 idle hold", 0, rnd_vec(), rnd_vec(), rnd_vec(), rnd_pred());
    end

    step("R5 fields", 1, mk_insn(2'd2, 3'd6, 5'd21, 5'd10), rnd_vec(), rnd_vec(), rnd_pred());
    step("R5 fields", 1, mk_insn(2'd1, 3'd1, 5'd31, 5'd0), rnd_vec(), rnd_vec(), rnd_pred());
    step("R6 bad top byte", 1, mk_insn(2'd0, 3'd0, 5'd1, 5'd1) ^ 32'h8000_0000,
         rnd_vec(), rnd_vec(), '1);
    step("R6 bad bit13", 1, mk_insn(2'd3, 3'd2, 5'd2, 5'd2) ^ 32'h0000_2000,
         rnd_vec(), rnd_vec(), '1);
    step("R6 bad bit21", 1, mk_insn(2'd1, 3'd3, 5'd3, 5'd3) ^ 32'h0020_0000,
         rnd_vec(), rnd_vec(), '1);
    step("R7 idle after illegal", 0, '0, '0, '0, '0);
    step("R6 recovers", 1, mk_insn(2'd0, 3'd4, 5'd4, 5'd4), ones, ones, '1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule